// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Timing Generator

This block turns single register-access requests into complete parallel ATA programmed-I/O bus cycles. A request names the direction, the command or control register block, the 3-bit device register address and, for writes, the 16-bit data word. The block then drives the address and chip-select lines, asserts the read or write strobe, keeps the data bus enabled for writes, and releases everything in a fixed phase order. Each phase lasts a number of clock cycles held in a small bank of 8-bit timing registers.

Firmware converts the nanosecond figures of the selected PIO mode into clock counts and loads them through a one-field-at-a-time configuration port. After reset the bank holds counts for the fastest PIO mode at the configured clock period. Each count is rounded up as (t_ns + T) / T. The ready-window count gets two extra cycles to cover the two-stage synchronizer on the device ready line. When the ready check is enabled, a device that holds ready low at the end of the window stretches the strobe. The remaining pulse time then completes once ready returns. Read data is captured on the clock edge that ends the strobe and is presented with a one-cycle done pulse.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and done are 0, both strobes and both chip-selects are high (inactive), dd_oe is 0 and ata_da is 0.
- R2: With CLK_NS = 10, reset loads a setup count of 3, read and write pulse counts of 8, write-data hold and address hold counts of 2, a ready-window count of 8 and ready checking disabled. cfg_sel encodes the field: 0 setup, 1 write pulse, 2 read pulse, 3 write-data hold, 4 address hold, 5 ready window, 6 control (cfg_val bit 0 enables ready checking).
- R3: A request accepted at a clock edge drives ata_da and one chip-select low after that edge. The strobe falls max(setup,1) cycles later. req_ctl = 0 selects ata_cs0_n, and req_ctl = 1 selects ata_cs1_n.
- R4: A write lowers only ata_diow_n and a read lowers only ata_dior_n. Without a ready stall, the strobe stays low for max(pulse,1) cycles, using the write pulse count for writes and the read pulse count for reads.
- R5: For a write, dd_oe is 1 and dd_out carries req_wdata from the accepting edge until max(write-data hold,1) cycles after the strobe rises. For a read, dd_oe stays 0.
- R6: The chip-select and ata_da are released max(address hold,1) cycles after the strobe rises. busy falls and done pulses for one cycle max(address hold,1,write-data hold) cycles after the strobe rises.
- R7: For a read, dd_in is sampled on the clock edge that ends the strobe. rd_data holds that value while done is 1.
- R8: With ready checking enabled, if the synchronized iordy is low after max(window,1) strobe cycles, the strobe stays low until iordy is seen high, and then the remaining pulse cycles complete.
- R9: With ready checking disabled, a low iordy has no effect on the strobe width.
- R10: A count of 0 in any field behaves as a count of 1.
- R11: Only one cycle is in flight. A request presented while busy is 1 is dropped and starts no bus cycle.
- R12: Timing fields are captured when a request is accepted. A configuration write during a cycle takes effect only from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 3 | Timing field select |
| cfg_val | input | 8 | Value written to the selected field |
| req_valid | input | 1 | Request; taken when busy is 0 |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ctl | input | 1 | 1 = control block (cs1), 0 = command block (cs0) |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| ata_da | output | 3 | Device address lines |
| ata_cs0_n | output | 1 | Command block chip-select, active low |
| ata_cs1_n | output | 1 | Control block chip-select, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Data bus value driven for writes |
| dd_oe | output | 1 | Data bus output enable |
| dd_in | input | 16 | Data bus value from the device |
| iordy | input | 1 | Device ready, asynchronous |

## Verification
A wrong phase counter shows up as a strobe edge, chip-select release or data-enable release landing one or more cycles away from the programmed count. The bench sees this within the same bus cycle, because it measures each phase width in cycles at the ports. A wrong state encoding or stuck stall condition shows up as both strobes low together, a strobe with no chip-select, or a strobe that never rises. The checker flags these on the cycle they occur, and the bench watchdog flags a hung cycle. A wrongly captured read word or a field latched at the wrong time shows up at the next done pulse, as a data or width mismatch against the scoreboard entry.

// File: rtl/pio_tmg_pkg.sv
package pio_tmg_pkg;

    localparam int PIO_CNT_W  = 8;
    localparam int PIO_DA_W   = 3;
    localparam int PIO_DATA_W = 16;

    // fastest PIO mode figures in ns
    localparam int NS_SETUP = 25;
    localparam int NS_PULSE = 70;
    localparam int NS_WHOLD = 10;
    localparam int NS_AHOLD = 10;
    localparam int NS_RDYWIN = 50;
    localparam int RDY_SYNC_EXTRA = 2;

    typedef logic [PIO_CNT_W-1:0]  cnt_t;
    typedef logic [PIO_DATA_W-1:0] word_t;
    typedef logic [PIO_DA_W-1:0]   da_t;

    typedef enum logic [2:0] {
        SEL_SETUP  = 3'd0,
        SEL_WPULSE = 3'd1,
        SEL_RPULSE = 3'd2,
        SEL_WHOLD  = 3'd3,
        SEL_AHOLD  = 3'd4,
        SEL_RDYWIN = 3'd5,
        SEL_CTRL   = 3'd6
    } cfg_sel_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t wpulse;
        cnt_t rpulse;
        cnt_t whold;
        cnt_t ahold;
        cnt_t rdywin;
        logic rdy_en;
    } pio_cfg_t;

    typedef struct packed {
        logic  write;
        logic  ctl;
        da_t   addr;
        word_t wdata;
    } pio_req_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } pio_phase_e;

    localparam cnt_t CNT_ONE = cnt_t'(1);

    function automatic cnt_t ns_to_cnt(input int ns, input int clk_ns, input int extra);
        return cnt_t'((ns + clk_ns) / clk_ns + extra);
    endfunction

    function automatic cnt_t at_least_one(input cnt_t c);
        return (c == '0) ? CNT_ONE : c;
    endfunction

    function automatic pio_cfg_t reset_cfg(input int clk_ns);
        pio_cfg_t c;
        c.setup  = ns_to_cnt(NS_SETUP, clk_ns, 0);
        c.wpulse = ns_to_cnt(NS_PULSE, clk_ns, 0);
        c.rpulse = ns_to_cnt(NS_PULSE, clk_ns, 0);
        c.whold  = ns_to_cnt(NS_WHOLD, clk_ns, 0);
        c.ahold  = ns_to_cnt(NS_AHOLD, clk_ns, 0);
        c.rdywin = ns_to_cnt(NS_RDYWIN, clk_ns, RDY_SYNC_EXTRA);
        c.rdy_en = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pio_tmg_regs.sv
module pio_tmg_regs
    import pio_tmg_pkg::*;
#(
    parameter int CLK_NS = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_we,
    input  logic [2:0] cfg_sel,
    input  cnt_t     cfg_val,
    output pio_cfg_t cfg
);
    localparam pio_cfg_t CFG_RST = reset_cfg(CLK_NS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RST;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_SETUP:  cfg.setup  <= cfg_val;
                SEL_WPULSE: cfg.wpulse <= cfg_val;
                SEL_RPULSE: cfg.rpulse <= cfg_val;
                SEL_WHOLD:  cfg.whold  <= cfg_val;
                SEL_AHOLD:  cfg.ahold  <= cfg_val;
                SEL_RDYWIN: cfg.rdywin <= cfg_val;
                SEL_CTRL:   cfg.rdy_en <= cfg_val[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pio_rdy_sync.sv
module pio_rdy_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= {STAGES{RESET_VAL}};
        else     shreg <= {shreg[STAGES-2:0], d_async};
    end

    assign q_sync = shreg[STAGES-1];
endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
    import pio_tmg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pio_cfg_t cfg,
    input  logic     req_valid,
    input  pio_req_t req,
    input  logic     rdy_s,
    input  word_t    dd_in,
    output logic     busy,
    output logic     done,
    output word_t    rd_data,
    output da_t      ata_da,
    output logic     ata_cs0_n,
    output logic     ata_cs1_n,
    output logic     ata_dior_n,
    output logic     ata_diow_n,
    output word_t    dd_out,
    output logic     dd_oe
);
    pio_phase_e ph;
    logic cur_write;
    logic lat_rdy_en;
    cnt_t lat_pulse, lat_win, lat_ahold, lat_whold;
    cnt_t cnt, rem, win, ha, hd;
    cnt_t ha_nx, hd_nx;
    logic stall;

    assign busy  = (ph != PH_IDLE);
    assign stall = lat_rdy_en && (win == CNT_ONE) && !rdy_s;

    always_comb begin
        ha_nx = (ha != '0) ? ha - CNT_ONE : '0;
        hd_nx = (hd != '0) ? hd - CNT_ONE : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_IDLE;
            cur_write  <= 1'b0;
            lat_rdy_en <= 1'b0;
            lat_pulse  <= '0;
            lat_win    <= '0;
            lat_ahold  <= '0;
            lat_whold  <= '0;
            cnt        <= '0;
            rem        <= '0;
            win        <= '0;
            ha         <= '0;
            hd         <= '0;
            done       <= 1'b0;
            rd_data    <= '0;
            ata_da     <= '0;
            ata_cs0_n  <= 1'b1;
            ata_cs1_n  <= 1'b1;
            ata_dior_n <= 1'b1;
            ata_diow_n <= 1'b1;
            dd_out     <= '0;
            dd_oe      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_write  <= req.write;
                        lat_rdy_en <= cfg.rdy_en;
                        lat_pulse  <= at_least_one(req.write ? cfg.wpulse : cfg.rpulse);
                        lat_win    <= at_least_one(cfg.rdywin);
                        lat_ahold  <= at_least_one(cfg.ahold);
                        lat_whold  <= at_least_one(cfg.whold);
                        cnt        <= at_least_one(cfg.setup) - CNT_ONE;
                        ata_da     <= req.addr;
                        ata_cs0_n  <= req.ctl;
                        ata_cs1_n  <= !req.ctl;
                        dd_oe      <= req.write;
                        dd_out     <= req.wdata;
                        ph         <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        if (cur_write) ata_diow_n <= 1'b0;
                        else           ata_dior_n <= 1'b0;
                        rem <= lat_pulse;
                        win <= lat_win;
                        ph  <= PH_PULSE;
                    end else begin
                        cnt <= cnt - CNT_ONE;
                    end
                end
                PH_PULSE: begin
                    if (!stall) begin
                        win <= (win != '0) ? win - CNT_ONE : '0;
                        if (rem == CNT_ONE) begin
                            ata_dior_n <= 1'b1;
                            ata_diow_n <= 1'b1;
                            if (!cur_write) rd_data <= dd_in;
                            ha <= lat_ahold;
                            hd <= lat_whold;
                            ph <= PH_HOLD;
                        end else begin
                            rem <= rem - CNT_ONE;
                        end
                    end
                end
                PH_HOLD: begin
                    ha <= ha_nx;
                    hd <= hd_nx;
                    if (ha_nx == '0) begin
                        ata_cs0_n <= 1'b1;
                        ata_cs1_n <= 1'b1;
                        ata_da    <= '0;
                    end
                    if (hd_nx == '0) dd_oe <= 1'b0;
                    if (ha_nx == '0 && hd_nx == '0) begin
                        done <= 1'b1;
                        ph   <= PH_IDLE;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_tmg_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int SYNC_STG = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [7:0]  cfg_val,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_ctl,
    input  logic [2:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic [2:0]  ata_da,
    output logic        ata_cs0_n,
    output logic        ata_cs1_n,
    output logic        ata_dior_n,
    output logic        ata_diow_n,
    output logic [15:0] dd_out,
    output logic        dd_oe,
    input  logic [15:0] dd_in,
    input  logic        iordy
);
    pio_cfg_t cfg;
    pio_req_t req_s;
    logic     rdy_s;

    assign req_s = '{write: req_write, ctl: req_ctl, addr: req_addr, wdata: req_wdata};

    pio_tmg_regs #(.CLK_NS(CLK_NS)) regs_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_val(cfg_val), .cfg(cfg)
    );

    pio_rdy_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) sync_i (
        .clk(clk), .rst(rst), .d_async(iordy), .q_sync(rdy_s)
    );

    pio_cycle_fsm fsm_i (
        .clk(clk), .rst(rst), .cfg(cfg), .req_valid(req_valid), .req(req_s),
        .rdy_s(rdy_s), .dd_in(dd_in), .busy(busy), .done(done),
        .rd_data(rd_data), .ata_da(ata_da), .ata_cs0_n(ata_cs0_n),
        .ata_cs1_n(ata_cs1_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe)
    );
endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic ata_cs0_n,
    input logic ata_cs1_n,
    input logic ata_dior_n,
    input logic ata_diow_n,
    input logic dd_oe
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!ata_dior_n && !ata_diow_n));

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!ata_cs0_n, !ata_cs1_n}));

    // R3
    strobe_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));

    // R5
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !ata_dior_n |-> !dd_oe);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!ata_dior_n || !ata_diow_n) |-> busy);
endmodule

bind pio_strobe_gen pio_strobe_chk chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .dd_oe(dd_oe)
);

// File: tb/pio_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module pio_strobe_gen_tb_top;
    import pio_tmg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int T_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_val = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ctl = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic [2:0]  ata_da;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic [15:0] dd_in = '0;
    logic        iordy = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_strobe_gen #(.CLK_NS(T_NS)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
        .req_valid(req_valid), .req_write(req_write), .req_ctl(req_ctl),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .ata_da(ata_da), .ata_cs0_n(ata_cs0_n),
        .ata_cs1_n(ata_cs1_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
    );

    int nchk = 0;
    int nerr = 0;
    int npush = 0;
    int nmon = 0;

    typedef struct {
        int setup;
        int pulse;
        int ahold;
        int whold;
        int total;
        bit write;
        bit ctl;
        logic [2:0]  addr;
        logic [15:0] wdata;
        logic [15:0] rdata;
    } exp_t;
    exp_t q[$];

    // shadow of the timing bank; reset values from R2: (ns + T) / T, window + 2
    int s_setup  = (25 + T_NS) / T_NS;
    int s_wpulse = (70 + T_NS) / T_NS;
    int s_rpulse = (70 + T_NS) / T_NS;
    int s_whold  = (10 + T_NS) / T_NS;
    int s_ahold  = (10 + T_NS) / T_NS;
    int s_rdywin = (50 + T_NS) / T_NS + 2;
    bit s_rdyen  = 1'b0;

    function automatic int eff(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_val = val[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: s_setup  = val;
            3'd1: s_wpulse = val;
            3'd2: s_rpulse = val;
            3'd3: s_whold  = val;
            3'd4: s_ahold  = val;
            3'd5: s_rdywin = val;
            3'd6: s_rdyen  = val[0];
            default: ;
        endcase
    endtask

    // driver: waits for idle, pushes the expected item, issues the request
    task automatic do_xfer(input bit wr, input bit ctl, input logic [2:0] a,
                           input logic [15:0] wd, input logic [15:0] rd, input int pulse_ovr);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.setup = eff(s_setup);
        e.pulse = (pulse_ovr >= 0) ? pulse_ovr : eff(wr ? s_wpulse : s_rpulse);
        e.ahold = eff(s_ahold);
        e.whold = wr ? eff(s_whold) : 0;
        e.total = imax(eff(s_ahold), eff(s_whold));
        e.write = wr; e.ctl = ctl; e.addr = a; e.wdata = wd; e.rdata = rd;
        q.push_back(e);
        npush++;
        dd_in = rd;
        req_valid = 1'b1; req_write = wr; req_ctl = ctl; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: measures each bus cycle at the ports and compares with the queue
    initial begin : monitor
        forever begin
            int su, pw, d, ah, wh;
            bit was_rd, was_wr, oe_rd;
            logic c0, c1, oe_at;
            logic [2:0] da_at;
            logic [15:0] do_at, rdv;
            exp_t e;
            @(negedge clk);
            if (rst || (ata_cs0_n && ata_cs1_n)) continue;
            su = 0; oe_rd = 1'b0;
            while (ata_dior_n && ata_diow_n && su < 1000) begin
                @(negedge clk); su++;
            end
            was_rd = !ata_dior_n; was_wr = !ata_diow_n;
            c0 = ata_cs0_n; c1 = ata_cs1_n; da_at = ata_da; do_at = dd_out; oe_at = dd_oe;
            pw = 0;
            while ((!ata_dior_n || !ata_diow_n) && pw < 1000) begin
                if (dd_oe && was_rd) oe_rd = 1'b1;
                @(negedge clk); pw++;
            end
            d = 0; ah = -1; wh = -1;
            forever begin
                if (ah < 0 && ata_cs0_n && ata_cs1_n) ah = d;
                if (wh < 0 && !dd_oe) wh = d;
                if (done || d > 1000) break;
                @(negedge clk); d++;
            end
            rdv = rd_data;
            nmon++;
            if (q.size() == 0) begin
                chk(1'b0, "R11 unexpected bus cycle", 1, 0);
                continue;
            end
            e = q.pop_front();
            chk(su == e.setup, "R3 setup cycles", su, e.setup);
            chk((c0 == e.ctl) && (c1 == !e.ctl), "R3 chip-select choice", {c0, c1}, {e.ctl, !e.ctl});
            chk(da_at == e.addr, "R3 device address", da_at, e.addr);
            chk(was_wr == e.write && was_rd == !e.write, "R4 strobe kind", {was_wr, was_rd}, {e.write, !e.write});
            chk(pw == e.pulse, "R4/R8/R10 strobe width", pw, e.pulse);
            chk(ah == e.ahold, "R6 address hold", ah, e.ahold);
            chk(d == e.total, "R6 cycles to done", d, e.total);
            if (e.write) begin
                chk(wh == e.whold, "R5 write data hold", wh, e.whold);
                chk(oe_at && do_at == e.wdata, "R5 write data driven", do_at, e.wdata);
            end else begin
                chk(!oe_rd && !oe_at, "R5 no drive on read", oe_rd, 0);
                chk(rdv == e.rdata, "R7 read data", rdv, e.rdata);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL R11 watchdog: actual=hung expected=idle");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        // R1 during reset
        chk(!busy && !done && ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !dd_oe && ata_da == 0,
            "R1 reset outputs", {busy, done, dd_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && ata_dior_n && ata_diow_n && !dd_oe, "R1 first cycle after reset", {busy, done}, 0);

        // R2 default timings: write on command block, then read on control block
        do_xfer(1'b1, 1'b0, 3'd3, 16'hA55A, 16'h0, -1);
        do_xfer(1'b0, 1'b1, 3'd6, 16'h0, 16'h1234, -1);

        // R11 request while busy is dropped; R12 config write during cycle is not applied
        do_xfer(1'b1, 1'b0, 3'd1, 16'h0F0F, 16'h0, -1);
        req_valid = 1'b1; req_write = 1'b0; req_ctl = 1'b1; req_addr = 3'd7;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_write(3'd1, 4);
        do_xfer(1'b1, 1'b1, 3'd2, 16'h8001, 16'h0, -1);

        // R5/R6 write-data hold longer than address hold
        cfg_write(3'd0, 5);
        cfg_write(3'd3, 6);
        cfg_write(3'd4, 2);
        do_xfer(1'b1, 1'b0, 3'd5, 16'hC3C3, 16'h0, -1);
        cfg_write(3'd0, 3);
        cfg_write(3'd3, 2);

        // R9 iordy low with checking disabled: default read width
        iordy = 1'b0;
        repeat (4) @(negedge clk);
        do_xfer(1'b0, 1'b0, 3'd0, 16'h0, 16'h5AA5, -1);

        // R8 enabled: iordy raised 10 cycles after strobe falls -> 10 + 3 + P - W
        cfg_write(3'd6, 1);
        do_xfer(1'b0, 1'b0, 3'd4, 16'h0, 16'hBEEF, 10 + 3 + eff(s_rpulse) - eff(s_rdywin));
        while (ata_dior_n) @(negedge clk);
        repeat (10) @(negedge clk);
        iordy = 1'b1;

        // R10 zero counts act as one
        cfg_write(3'd0, 0);
        cfg_write(3'd2, 0);
        cfg_write(3'd3, 0);
        cfg_write(3'd4, 0);
        do_xfer(1'b0, 1'b1, 3'd1, 16'h0, 16'h7E7E, -1);

        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R11 pending expected items", q.size(), 0);
        chk(nmon == npush, "R11 bus cycles seen", nmon, npush);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule